// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from up to sixteen sources into a latched status register. It gates them with a mask register and drives a single level-sensitive pending line toward the processor. Each peripheral raises its status bit with a one-cycle request pulse. Bit 3 is tied to the DMA controller through a dedicated request input.

Software reaches the two registers through a small write/read port with byte-offset addressing. It clears status bits by writing zeros to them, because a write is AND-ed into the status register. It enables sources by overwriting the mask. When a mask write exposes a source that was already latched, the block emits a one-cycle recheck pulse. The processor side can then re-evaluate its interrupt state even if it missed the level change.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `src_req` sets status bit i at the next clock edge. The bit stays set until it is acknowledged.
- R2: A write to offset 0x70 replaces the status with (old status AND low 16 bits of the write data). A written 0 clears a bit and a written 1 leaves it as it was.
- R3: A write to offset 0x74 replaces the mask with the low 16 bits of the write data.
- R4: Bits 31..16 of the write data have no effect on either register. A read at 0x70 or 0x74 returns that register zero-extended to 32 bits, with bits 31..16 equal to 0.
- R5: `cpu_pending` is a registered output that equals 1 exactly when (status AND mask) is nonzero. It follows the register values that result from a write or request, one clock edge after that write or request is presented.
- R6: A pulse on `dma_req` sets status bit 3.
- R7: Synchronous active-high reset clears status and mask, and drives `cpu_pending` and `recheck` low.
- R8: `recheck` is high for exactly one cycle after a mask write for which (status before the write AND new mask) is nonzero. Otherwise it stays low.
- R9: When a request and an acknowledge write hit the same status bit in the same cycle, the request wins and the bit ends up set.
- R10: Writes to any offset other than 0x70 and 0x74 change neither register. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; only bits 15..0 are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_req | input | 16 | Per-source request pulses |
| dma_req | input | 1 | DMA controller request pulse, merged into bit 3 |
| cpu_pending | output | 1 | Level interrupt line to the processor |
| recheck | output | 1 | One-cycle pulse when a mask write exposes a latched source |

## Verification
The acknowledge path is driven with patterns that mix zeros and ones, and with garbage in the upper half. This shows the AND semantics apart from a plain overwrite and from the use of wide data. Mask writes are tried once overlapping latched status and once disjoint from it, which shows whether the recheck pulse depends on the old status rather than firing on every mask write. A request colliding with an acknowledge of the same bit shows whether set has priority. A write to an unmapped offset confirms that the decode is exact.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int STAT_W = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_STAT = 2'd1,
        TGT_MASK = 2'd2
    } reg_tgt_e;

    typedef struct packed {
        reg_tgt_e            tgt;
        logic                valid;
        logic [STAT_W-1:0]   data;
    } wr_cmd_t;

    // Next value of one status bit: acknowledge by AND, request wins.
    function automatic logic stat_bit_next(input logic cur, input logic ack_wr,
                                           input logic ack_bit, input logic req);
        logic kept;
        kept = ack_wr ? (cur & ack_bit) : cur;
        return kept | req;
    endfunction

    function automatic logic [BUS_W-1:0] zext(input logic [STAT_W-1:0] v);
        return {{(BUS_W-STAT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/irq_regif.sv
module irq_regif
    import irq_ctrl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [STAT_W-1:0] mask_q,
    output wr_cmd_t           cmd,
    output logic [BUS_W-1:0]  bus_rdata
);
    reg_tgt_e tgt;
    logic     unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:STAT_W];

    always_comb begin
        if (bus_addr == STAT_OFS)      tgt = TGT_STAT;
        else if (bus_addr == MASK_OFS) tgt = TGT_MASK;
        else                           tgt = TGT_NONE;
    end

    always_comb begin
        cmd.tgt   = tgt;
        cmd.valid = bus_wr && (tgt != TGT_NONE);
        cmd.data  = bus_wdata[STAT_W-1:0];
    end

    always_comb begin
        case (tgt)
            TGT_STAT: bus_rdata = zext(stat_q);
            TGT_MASK: bus_rdata = zext(mask_q);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_ctrl_pkg::*;
#(
    parameter int DMA_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [STAT_W-1:0] src_req,
    input  logic              dma_req,
    output logic [STAT_W-1:0] stat_d,
    output logic [STAT_W-1:0] stat_q
);
    logic ack_wr;
    logic [STAT_W-1:0] req_all;

    assign ack_wr = cmd.valid && (cmd.tgt == TGT_STAT);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == DMA_BIT) begin : g_dma
            assign req_all[i] = src_req[i] | dma_req;
        end else begin : g_plain
            assign req_all[i] = src_req[i];
        end
        assign stat_d[i] = stat_bit_next(stat_q[i], ack_wr, cmd.data[i], req_all[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    output logic              mask_wr,
    output logic [STAT_W-1:0] mask_d,
    output logic [STAT_W-1:0] mask_q
);
    assign mask_wr = cmd.valid && (cmd.tgt == TGT_MASK);
    assign mask_d  = mask_wr ? cmd.data : mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/irq_event_gen.sv
module irq_event_gen
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [STAT_W-1:0] stat_d,
    input  logic [STAT_W-1:0] mask_d,
    input  logic              mask_wr,
    output logic              pending,
    output logic              recheck
);
    logic expose;

    // Old status against the new mask value being written.
    assign expose = mask_wr && ((stat_q & mask_d) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            recheck <= 1'b0;
        end else begin
            pending <= (stat_d & mask_d) != '0;
            recheck <= expose;
        end
    end
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74,
    parameter int                DMA_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [STAT_W-1:0] src_req,
    input  logic              dma_req,
    output logic              cpu_pending,
    output logic              recheck
);
    wr_cmd_t           cmd;
    logic [STAT_W-1:0] stat_d, stat_q;
    logic [STAT_W-1:0] mask_d, mask_q;
    logic              mask_wr;

    irq_regif #(.STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_regif (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .cmd      (cmd),
        .bus_rdata(bus_rdata)
    );

    irq_status_reg #(.DMA_BIT(DMA_BIT)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .src_req(src_req),
        .dma_req(dma_req),
        .stat_d (stat_d),
        .stat_q (stat_q)
    );

    irq_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mask_wr(mask_wr),
        .mask_d (mask_d),
        .mask_q (mask_q)
    );

    irq_event_gen u_evt (
        .clk    (clk),
        .rst    (rst),
        .stat_q (stat_q),
        .stat_d (stat_d),
        .mask_d (mask_d),
        .mask_wr(mask_wr),
        .pending(cpu_pending),
        .recheck(recheck)
    );
endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk
    import irq_ctrl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [STAT_W-1:0] src_req,
    input logic              dma_req,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              cpu_pending,
    input logic              recheck
);
    p_req_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (src_req != '0) |=> (($past(src_req) & ~stat_q) == '0));

    p_ack_and_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == STAT_OFS && src_req == '0 && !dma_req)
        |=> (stat_q == ($past(stat_q) & $past(bus_wdata[STAT_W-1:0]))));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == MASK_OFS) |=> (mask_q == $past(bus_wdata[STAT_W-1:0])));

    p_pending_level_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_pending == ((stat_q & mask_q) != '0));

    p_recheck_cause_r8: assert property (@(posedge clk) disable iff (rst)
        recheck |-> ($past(bus_wr && bus_addr == MASK_OFS) &&
                     (($past(stat_q) & mask_q) != '0)));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != STAT_OFS && bus_addr != MASK_OFS &&
         src_req == '0 && !dma_req) |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

bind irq_stat_mask_ctrl irq_stat_mask_chk #(.STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .src_req    (src_req),
    .dma_req    (dma_req),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .cpu_pending(cpu_pending),
    .recheck    (recheck)
);

// File: tb/irq_stat_mask_ctrl_tb.sv
module irq_stat_mask_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] src_req = '0;
    logic        dma_req = 1'b0;
    logic        cpu_pending;
    logic        recheck;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_stat_mask_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .dma_req(dma_req), .cpu_pending(cpu_pending), .recheck(recheck)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Drive at a falling edge, release at the next one; results settle there.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; src_req = req;
        @(negedge clk);
        bus_wr = 1'b0; src_req = '0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [15:0] req, input logic dma);
        @(negedge clk);
        src_req = req; dma_req = dma;
        @(negedge clk);
        src_req = '0; dma_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h70, v); check("R7 status after reset", v, 32'h0);
        rd(8'h74, v); check("R7 mask after reset", v, 32'h0);
        check("R7 pending after reset", {31'b0, cpu_pending}, 32'h0);
        check("R7 recheck after reset", {31'b0, recheck}, 32'h0);
    endtask

    task automatic t_request;
        logic [31:0] v;
        pulse(16'h0005, 1'b0);
        rd(8'h70, v); check("R1 request latches bits", v, 32'h5);
        check("R5 masked request keeps pending low", {31'b0, cpu_pending}, 32'h0);
        @(negedge clk);
        rd(8'h70, v); check("R1 bits hold after pulse", v, 32'h5);
    endtask

    task automatic t_dma;
        logic [31:0] v;
        pulse(16'h0000, 1'b1);
        rd(8'h70, v); check("R6 dma sets bit 3", v, 32'hD);
    endtask

    task automatic t_unmask_exposes;
        logic [31:0] v;
        wr(8'h74, 32'h0000_0004, '0);
        check("R8 recheck on exposing mask write", {31'b0, recheck}, 32'h1);
        check("R5 pending after unmask", {31'b0, cpu_pending}, 32'h1);
        rd(8'h74, v); check("R3 mask loaded", v, 32'h4);
        @(negedge clk);
        check("R8 recheck lasts one cycle", {31'b0, recheck}, 32'h0);
    endtask

    task automatic t_unmask_disjoint;
        wr(8'h74, 32'h0000_0100, '0);
        check("R8 no recheck on disjoint mask", {31'b0, recheck}, 32'h0);
        check("R5 pending drops with disjoint mask", {31'b0, cpu_pending}, 32'h0);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr(8'h70, 32'hABCD_FFFB, '0);
        rd(8'h70, v); check("R2 ack clears only zero bits (R4 upper ignored)", v, 32'h9);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        wr(8'h70, 32'h0000_FFFE, 16'h0001);
        rd(8'h70, v); check("R9 request beats ack", v, 32'h9);
    endtask

    task automatic t_wide_mask;
        logic [31:0] v;
        wr(8'h74, 32'h1234_0008, '0);
        rd(8'h74, v); check("R4 mask upper half ignored, zero read", v, 32'h8);
        check("R8 recheck with bit 3 latched", {31'b0, recheck}, 32'h1);
        check("R5 pending with bit 3 masked in", {31'b0, cpu_pending}, 32'h1);
    endtask

    task automatic t_ack_drops_pending;
        logic [31:0] v;
        wr(8'h70, 32'h0000_FFF7, '0);
        rd(8'h70, v); check("R2 bit 3 acknowledged", v, 32'h1);
        check("R5 pending falls on ack", {31'b0, cpu_pending}, 32'h0);
        pulse(16'h0008, 1'b0);
        check("R5 pending rises one edge after request", {31'b0, cpu_pending}, 32'h1);
        check("R8 no recheck on request", {31'b0, recheck}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h78, 32'h0000_0000, '0);
        wr(8'h72, 32'h0000_0000, '0);
        rd(8'h70, v); check("R10 status untouched", v, 32'h9);
        rd(8'h74, v); check("R10 mask untouched", v, 32'h8);
        rd(8'h78, v); check("R10 unmapped read zero", v, 32'h0);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_request();
        t_dma();
        t_unmask_exposes();
        t_unmask_disjoint();
        t_ack();
        t_collision();
        t_wide_mask();
        t_ack_drops_pending();
        t_unmapped();
        t_reset_again();
        done = 1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end
endmodule